// File: doc/BRIEF.md
# Serial SAR Converter Interface Sequencer

This block is the digital control side of a five-channel, 10-bit successive-approximation converter that sits behind a three-wire synchronous serial port: an active-low select, a serial clock and a data line in each direction. Every transfer does three jobs at once. It returns the code of the previous conversion, it takes in the 4-bit input address for the next conversion, and it marks the window in which the chosen input is sampled. Once the sample window closes, the block hands off to the free-running system clock. That clock makes one bit decision per cycle from MSB to LSB, and an end-of-conversion flag shows when a fresh code is ready.

The analog array and comparator are modelled digitally. A trial code is compared against a 10-bit level taken from the `ch_level` bus, or against a fixed internal level when a self-test address is used. All three serial inputs are brought into the system clock domain through a two-stage synchroniser, so the serial clock must stay slower than the system clock. The serial pins follow a fixed edge protocol, so they carry no valid/ready handshake. The master paces the block with the serial clock and uses `eoc` to tell when it may start the next transfer.

A transfer may run 10 to 16 serial clocks when select is released between transfers. When select stays low, each transfer must be exactly 10 or exactly 16 clocks. The port tells a long transfer from a short one by whether a rising serial clock edge arrives while the conversion is still running. If a long transfer has no such edge, the port loses framing, and only a select toggle brings it back.

Top module: `serial_sar_seq`

## Requirements
- R1: The input address is 4 bits, MSB first, taken from `sdin` on the first four rising `sclk` edges of a transfer; later rising edges in the same transfer do not change it.
- R2: `sdout` shows the MSB of the stored result from the start of the transfer and moves to the next bit after each of the first nine falling `sclk` edges, so that all ten bits are read MSB first before the tenth falling edge.
- R3: `samp_win` rises after the fourth falling `sclk` edge and falls after the tenth; `eoc` drops low after the tenth falling edge.
- R4: `eoc` stays low for exactly 10 system clock cycles per conversion; when it rises, the new code is stored and becomes the next result read out.
- R5: Address codes 0 to 4 convert `ch_level` slice 0 to 4 (bits [10*i+9:10*i]). Code 0xB gives 0x200, code 0xC gives 0x000 and code 0xD gives 0x3FF. Every other code gives 0x000.
- R6: With `cs_n` high, `sdout_en` is 0 and `sdout` is 0. Raising `cs_n` ends a transfer of any length from 10 to 16 clocks, and the next select assertion starts a fresh transfer.
- R7: With `cs_n` held low and 10 clocks per transfer, the next transfer begins with the first rising edge after `eoc` has risen.
- R8: With `cs_n` held low and 16 clocks per transfer, a rising edge during the conversion makes the port ignore clocks 11 to 16. The port re-arms after the sixteenth falling edge.
- R9: If a 16-clock transfer with `cs_n` held low sees no rising edge during the conversion, the port re-arms as soon as the conversion ends. Its remaining clocks then count toward the next frame, so in the following transfer `eoc` drops after the fourth falling edge instead of the tenth. Framing returns only after `cs_n` is raised and lowered again.
- R10: After reset the stored result is 0x000, `eoc` is 1, and `sdout_en` and `samp_win` are 0.
- R11: With 10 clocks per transfer, a serial clock slower than the conversion time still gives correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdin | input | 1 | Serial address in, MSB first |
| sdout | output | 1 | Serial result out, MSB first; 0 when not driven |
| sdout_en | output | 1 | High while `sdout` is driven |
| eoc | output | 1 | End of conversion; low while converting |
| samp_win | output | 1 | High during the input sample window |
| ch_level | input | 50 | Five 10-bit input levels, channel i at bits [10*i+9:10*i] |

## Verification
Transfers with select toggled are run at lengths 10, 11, 12, 13, 14 and 16. Across them, every channel, every self-test code and two reserved codes are addressed, so a fault in address decoding or bit order shows up as a wrong code in the following readout. Back-to-back 10-clock and 16-clock runs with select held low separate the two re-arm rules: one port re-arms when the conversion ends, the other after the sixteenth edge. A slow-clock 10-clock run confirms that no minimum clock rate applies. A slow 16-clock run with select held low must put `eoc` low after the fourth edge of the next transfer, and a select toggle must then restore correct readout.

// File: rtl/serial_sar_pkg.sv
package serial_sar_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_FRAME = 2'd1,
    PS_WAIT  = 2'd2,
    PS_TAIL  = 2'd3
  } port_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{INIT}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sar_level_sel.sv
module sar_level_sel #(
  parameter int DW = 10,
  parameter int NCH = 5,
  parameter int AW = 4
) (
  input  logic [AW-1:0]     addr,
  input  logic [NCH*DW-1:0] levels,
  output logic [DW-1:0]     level
);
  localparam logic [AW-1:0] CODE_MID  = AW'(11);
  localparam logic [AW-1:0] CODE_LOW  = AW'(12);
  localparam logic [AW-1:0] CODE_HIGH = AW'(13);
  localparam logic [DW-1:0] LVL_MID   = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] lv [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_lv
    assign lv[g] = levels[g*DW +: DW];
  end

  always_comb begin
    level = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) level = lv[i];
    end
    if (addr == CODE_MID)  level = LVL_MID;
    if (addr == CODE_LOW)  level = '0;
    if (addr == CODE_HIGH) level = '1;
  end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] level,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic [DW-1:0] held
);
  localparam int SW = $clog2(DW);

  logic [DW-1:0] code_q;
  logic [SW-1:0] step_q;
  logic [DW-1:0] cand;
  logic          keep;

  assign cand = code_q | (DW'(1) << step_q);
  assign keep = (cand <= held);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      held   <= '0;
      code_q <= '0;
      step_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          held   <= level;
          code_q <= '0;
          step_q <= SW'(DW-1);
        end
      end else begin
        code_q <= keep ? cand : code_q;
        if (step_q == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= keep ? cand : code_q;
        end else begin
          step_q <= step_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_port.sv
module sar_port
  import serial_sar_pkg::*;
#(
  parameter int DW = 10,
  parameter int AW = 4,
  parameter int MAXCLK = 16,
  localparam int CW = $clog2(MAXCLK+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          rise,
  input  logic          fall,
  input  logic          din,
  input  logic          done,
  input  logic [DW-1:0] result,
  output logic          bit_out,
  output logic [AW-1:0] addr,
  output logic          start,
  output logic          samp,
  output logic [CW-1:0] fcnt
);
  localparam int RW = $clog2(AW+1);
  localparam logic [CW-1:0] F_SAMP = CW'(AW);
  localparam logic [CW-1:0] F_HOLD = CW'(DW);
  localparam logic [CW-1:0] F_LAST = CW'(MAXCLK);
  localparam logic [CW-1:0] F_SHIFT_END = CW'(DW-1);

  port_state_e   st;
  logic [DW-1:0] sreg;
  logic [RW-1:0] rcnt;
  logic          rseen;
  logic [CW-1:0] fcnt_nx;
  logic          rearm;

  assign bit_out = sreg[DW-1];
  assign fcnt_nx = (fall && fcnt < F_LAST) ? fcnt + 1'b1 : fcnt;

  always_comb begin
    rearm = 1'b0;
    if (cs_act) begin
      unique case (st)
        PS_IDLE:  rearm = 1'b1;
        PS_WAIT:  rearm = done && (!(rseen || rise) || fcnt_nx == F_LAST);
        PS_TAIL:  rearm = (fcnt_nx == F_LAST);
        default:  rearm = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PS_IDLE;
      sreg  <= '0;
      rcnt  <= '0;
      fcnt  <= '0;
      addr  <= '0;
      start <= 1'b0;
      samp  <= 1'b0;
      rseen <= 1'b0;
    end else begin
      start <= 1'b0;
      if (!cs_act) begin
        st   <= PS_IDLE;
        samp <= 1'b0;
      end else begin
        unique case (st)
          PS_FRAME: begin
            if (rise && rcnt < RW'(AW)) begin
              addr <= {addr[AW-2:0], din};
              rcnt <= rcnt + 1'b1;
            end
            if (fall) begin
              fcnt <= fcnt_nx;
              if (fcnt < F_SHIFT_END) sreg <= {sreg[DW-2:0], 1'b0};
              if (fcnt_nx == F_SAMP) samp <= 1'b1;
              if (fcnt_nx == F_HOLD) begin
                samp  <= 1'b0;
                start <= 1'b1;
                st    <= PS_WAIT;
              end
            end
          end
          PS_WAIT: begin
            fcnt <= fcnt_nx;
            if (rise) rseen <= 1'b1;
            if (done) st <= PS_TAIL;
          end
          PS_TAIL: begin
            fcnt <= fcnt_nx;
          end
          default: ;
        endcase
        if (rearm) begin
          st    <= PS_FRAME;
          sreg  <= result;
          rcnt  <= '0;
          fcnt  <= '0;
          rseen <= 1'b0;
          samp  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_sar_seq.sv
module serial_sar_seq #(
  parameter int DW = 10,
  parameter int NCH = 5,
  parameter int AW = 4,
  parameter int MAXCLK = 16,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic              sdout,
  output logic              sdout_en,
  output logic              eoc,
  output logic              samp_win,
  input  logic [NCH*DW-1:0] ch_level
);
  localparam int CW = $clog2(MAXCLK+1);

  logic [2:0]    sync_q;
  logic          cs_s, sclk_s, din_s, sclk_d;
  logic          rise, fall, cs_act;
  logic          bit_out, start, busy;
  logic          conv_done;
  logic [DW-1:0] conv_result, conv_held, level;
  logic [AW-1:0] addr;
  logic [CW-1:0] port_fcnt;

  sar_sync #(.N(3), .STAGES(SYNC), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdin}), .q(sync_q)
  );

  assign {cs_s, sclk_s, din_s} = sync_q;
  assign cs_act = ~cs_s;
  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      sdout_en <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      sdout_en <= cs_act;
    end
  end

  sar_port #(.DW(DW), .AW(AW), .MAXCLK(MAXCLK)) u_port (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise(rise), .fall(fall),
    .din(din_s), .done(conv_done), .result(conv_result), .bit_out(bit_out),
    .addr(addr), .start(start), .samp(samp_win), .fcnt(port_fcnt)
  );

  sar_level_sel #(.DW(DW), .NCH(NCH), .AW(AW)) u_sel (
    .addr(addr), .levels(ch_level), .level(level)
  );

  sar_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .level(level), .busy(busy),
    .done(conv_done), .result(conv_result), .held(conv_held)
  );

  assign eoc   = ~busy;
  assign sdout = sdout_en & bit_out;
endmodule

// File: rtl/serial_sar_seq_chk.sv
module serial_sar_seq_chk #(
  parameter int DW = 10,
  parameter int MAXCLK = 16,
  localparam int CW = $clog2(MAXCLK+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sdout,
  input logic          sdout_en,
  input logic          eoc,
  input logic          samp_win,
  input logic          conv_done,
  input logic [DW-1:0] conv_result,
  input logic [DW-1:0] conv_held,
  input logic [CW-1:0] port_fcnt
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_cnt <= '0;
    else if (!eoc) low_cnt <= low_cnt + 1'b1;
    else           low_cnt <= '0;
  end

  a_r4_eoc_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> low_cnt < 16'(DW));

  a_r4_eoc_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> low_cnt == 16'(DW));

  a_r5_code_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> conv_result == conv_held);

  a_r3_eoc_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(samp_win) && sdout_en && eoc) |=> !eoc);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!sdout_en && !sdout));

  a_r8_edge_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    port_fcnt <= CW'(MAXCLK));
endmodule

bind serial_sar_seq serial_sar_seq_chk #(.DW(DW), .MAXCLK(MAXCLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdout(sdout), .sdout_en(sdout_en),
  .eoc(eoc), .samp_win(samp_win), .conv_done(conv_done),
  .conv_result(conv_result), .conv_held(conv_held), .port_fcnt(port_fcnt)
);

// File: tb/serial_sar_seq_tb_top.sv
`timescale 1ns/1ps
module serial_sar_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, sdin;
  logic        sdout, sdout_en, eoc, samp_win;
  logic [49:0] ch_level;

  int lv [5] = '{10'h155, 10'h2AA, 10'h001, 10'h3FE, 10'h123};
  int total = 0;
  int bad = 0;
  int stored = 0;
  int cycles = 0;
  int fall_idx = 0;
  int eoc_fall_at = -1;
  int low_run = 0;
  int cs_hi = 0;
  logic prev_eoc = 1'b1;

  always #5 clk = ~clk;

  serial_sar_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .sdout(sdout), .sdout_en(sdout_en), .eoc(eoc), .samp_win(samp_win),
    .ch_level(ch_level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_level(input int a);
    if (a >= 0 && a < 5) return lv[a];
    case (a)
      11: return 10'h200;
      12: return 10'h000;
      13: return 10'h3FF;
      default: return 0;
    endcase
  endfunction

  // per-clock reference monitor
  always @(negedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 180000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      if (!eoc) low_run++;
      if (eoc && !prev_eoc) begin
        check(low_run == 10, "R4 eoc low length", low_run, 10);
        low_run = 0;
      end
      if (prev_eoc && !eoc && eoc_fall_at < 0) eoc_fall_at = fall_idx;
      if (cs_n) cs_hi++; else cs_hi = 0;
      if (cs_hi == 5)
        check(!sdout_en && !sdout, "R6 output idle with select high",
              {sdout_en, sdout}, 0);
      prev_eoc = eoc;
    end
  end

  task automatic xfer(input int a, input int n, input int hp, input bit raise,
                      input bit chk, input int exp_fall, input int exp_data);
    logic [9:0] got = '0;
    logic [3:0] ab = a[3:0];
    if (cs_n) begin
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
    end
    eoc_fall_at = -1;
    fall_idx = 0;
    for (int i = 1; i <= n; i++) begin
      sdin = (i <= 4) ? ab[4-i] : 1'b0;
      repeat (hp) @(negedge clk);
      sclk = 1'b1;
      repeat (hp) @(negedge clk);
      if (i <= 10) got = {got[8:0], sdout};
      if (chk) begin
        if (i == 4)  check(samp_win == 1'b0, "R3 window closed before 4th fall", samp_win, 0);
        if (i == 5)  check(samp_win == 1'b1, "R3 window open after 4th fall", samp_win, 1);
        if (i == 10) check(samp_win == 1'b1, "R3 window open before 10th fall", samp_win, 1);
        if (i == 11) check(samp_win == 1'b0, "R3 window closed after 10th fall", samp_win, 0);
      end
      sclk = 1'b0;
      fall_idx = i;
    end
    repeat (hp) @(negedge clk);
    if (chk) check(int'(got) == exp_data, "R2 R1 R5 readout of previous code",
                   int'(got), exp_data);
    if (exp_fall > 0)
      check(eoc_fall_at == exp_fall, "R3 R9 eoc fall edge index", eoc_fall_at, exp_fall);
    if (raise) begin
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic wait_eoc();
    repeat (6) @(negedge clk);
    while (!eoc) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input int a, input int n, input int hp, input bit raise);
    xfer(a, n, hp, raise, 1'b1, 10, stored);
    wait_eoc();
    stored = exp_level(a);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) ch_level[i*10 +: 10] = lv[i][9:0];
    cs_n = 1'b1; sclk = 1'b0; sdin = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(eoc == 1'b1, "R10 eoc high after reset", eoc, 1);
    check(sdout_en == 1'b0 && sdout == 1'b0, "R10 output idle after reset", {sdout_en, sdout}, 0);
    check(samp_win == 1'b0, "R10 window closed after reset", samp_win, 0);

    // R6: select toggled, lengths 10..16; R5 channel and self-test codes
    run(0, 10, 5, 1);   // first read returns reset code 0 (R10)
    run(11, 12, 5, 1);
    run(12, 14, 5, 1);
    run(13, 16, 5, 1);
    run(7, 11, 5, 1);   // reserved code
    run(3, 13, 5, 1);
    // R7: select held low, 10 clocks each
    run(1, 10, 5, 0);
    run(4, 10, 5, 0);
    run(2, 10, 5, 1);
    // R8: select held low, 16 clocks each, edge during conversion
    run(3, 16, 5, 0);
    run(14, 16, 5, 0);
    run(4, 16, 5, 1);
    // R11: slow clock, 10 clocks each, select held low
    run(2, 10, 30, 0);
    run(1, 10, 30, 0);
    run(0, 10, 30, 1);
    // R9: slow 16-clock transfers with select held low lose framing
    xfer(1, 16, 30, 1'b0, 1'b1, 10, stored);
    xfer(2, 16, 30, 1'b1, 1'b0, 4, 0);
    wait_eoc();
    stored = lv[0];   // R9: port took zeros from the tail as its address
    run(13, 10, 5, 1);  // R9 recovery after select toggle
    run(0, 10, 5, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule